// File: doc/BRIEF.md
# Timer Compare Channel Bank

This block watches a free-running timer count and compares it, every cycle, against a bank of compare values. It drives a per-channel match strobe toward a waveform generator. It sets a sticky per-channel flag one timer clock after an equality. When the channel's enable is set, that flag raises an interrupt request.

The compare values are wider than the CPU data bus, so software writes each value in two steps. The high byte goes first, into a shared holding register. The low byte follows and commits the full value.

- In normal mode a commit updates the live compare value at once.
- In PWM mode a commit lands in a shadow buffer. The live value is reloaded from the shadow only at the top or at the bottom of the count. This keeps every PWM period whole and symmetrical.

The counter, the generator and the clocking sit outside the block. They supply the count, the top and bottom indications, and the mode selection.

Top module: `tcmp_bank`

## Requirements
- R1: During and after reset, flags, interrupt requests, live compare values, shadow values and the holding register are all zero.
- R2: `match_o[i]` is high in every cycle in which `cnt_i` equals the live compare value of channel i. Channels 0..3 are addressed by `bus_ch_i` values 0..3.
- R3: An equality on channel i sets `flag_o[i]` at the following clock edge. The flag then stays set until it is cleared.
- R4: `irq_o[i]` is high exactly when `flag_o[i]` and `irq_en_i[i]` are both high.
- R5: `irq_ack_i[i]` clears flag i at the next edge. An equality in the same cycle wins, and the flag stays set.
- R6: A cycle with `flag_clr_we_i` high clears every flag whose bit in `flag_clr_i` is one. Bits written as zero leave their flags unchanged, and an equality in the same cycle wins.
- R7: A bus write with `bus_hi_i`=1 stores `bus_data_i[1:0]` in the shared holding register. It changes no compare value.
- R8: In normal mode (`pwm_mode_i`=0), a bus write with `bus_hi_i`=0 loads {holding register, `bus_data_i`} into both the live and shadow values of the addressed channel at the next edge.
- R9: In PWM mode, a low-byte write loads only the shadow value. All live values reload from their shadows when `at_top_i` is high with `upd_top_i`=1, or when `at_bottom_i` is high with `upd_top_i`=0.
- R10: `force_i[i]` drives `match_o[i]` high in that cycle without an equality. It neither sets the flag nor raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 10 | Current timer count |
| at_top_i | input | 1 | Count is at its top value |
| at_bottom_i | input | 1 | Count is at its bottom value |
| pwm_mode_i | input | 1 | 1 = PWM (buffered), 0 = normal |
| upd_top_i | input | 1 | Shadow reload point: 1 = top, 0 = bottom |
| bus_we_i | input | 1 | Bus write strobe |
| bus_hi_i | input | 1 | 1 = high-byte write, 0 = low-byte commit |
| bus_ch_i | input | 2 | Channel addressed by the write |
| bus_data_i | input | 8 | Write data |
| flag_clr_we_i | input | 1 | Flag clear write strobe |
| flag_clr_i | input | 4 | Write-one-to-clear mask |
| irq_en_i | input | 4 | Per-channel interrupt enable |
| irq_ack_i | input | 4 | Per-channel interrupt acknowledge |
| force_i | input | 4 | Per-channel forced match strobe |
| match_o | output | 4 | Match strobe to the waveform generator |
| flag_o | output | 4 | Sticky compare flags |
| irq_o | output | 4 | Interrupt requests |

## Verification
Every live compare value, shadow value and the holding register is internal state. Any of them going wrong first shows as a `match_o` strobe at the wrong count, and one cycle later as a misplaced flag.

The bench sweeps the full count range after each write. A wrong value is therefore exposed within one count period of about 1024 cycles. A shadow that reloads at the wrong point shows up in the first period after the reload.

Flag and interrupt faults show on the very next edge. This is because the reference model is compared with all three outputs on every cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   typedef enum logic {
      RELOAD_AT_BOTTOM = 1'b0,
      RELOAD_AT_TOP    = 1'b1
   } reload_sel_e;

   function automatic logic reload_now(input logic pwm, input reload_sel_e sel,
                                       input logic top, input logic bottom);
      return pwm && ((sel == RELOAD_AT_TOP) ? top : bottom);
   endfunction
endpackage

// File: rtl/tcmp_hold_latch.sv
module tcmp_hold_latch #(
   parameter int CNT_W = 10,
   parameter int BUS_W = 8,
   parameter int N_CH  = 4,
   localparam int HI_W = CNT_W - BUS_W,
   localparam int CH_W = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             hi,
   input  logic [CH_W-1:0]  ch,
   input  logic [BUS_W-1:0] data,
   output logic [N_CH-1:0]  commit,
   output logic [CNT_W-1:0] value
);
   logic [HI_W-1:0] hold_q;
   logic            unused_hi_bits;

   assign unused_hi_bits = ^data[BUS_W-1:HI_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_q <= '0;
      else if (we && hi)  hold_q <= data[HI_W-1:0];
   end

   assign value = {hold_q, data};

   for (genvar g = 0; g < N_CH; g++) begin : g_dec
      assign commit[g] = we && !hi && (ch == CH_W'(g));
   end
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             pwm,
   input  logic             reload,
   input  logic             commit,
   input  logic [CNT_W-1:0] value,
   input  logic             force_m,
   input  logic             ack,
   input  logic             clr,
   input  logic             ien,
   output logic             match,
   output logic             flag,
   output logic             irq
);
   logic [CNT_W-1:0] live_q, shadow_q;
   logic             eq, flag_q;

   assign eq = (cnt == live_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q   <= '0;
         shadow_q <= '0;
      end else begin
         if (commit) shadow_q <= value;
         if (pwm) begin
            if (reload) live_q <= shadow_q;
         end else if (commit) begin
            live_q <= value;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (eq)           flag_q <= 1'b1;
      else if (ack || clr)   flag_q <= 1'b0;
   end

   assign match = eq || force_m;
   assign flag  = flag_q;
   assign irq   = flag_q && ien;

   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eq |=> flag);
   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !eq) |=> !flag);
   p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !eq) |=> !flag);
   p_direct_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !pwm) |=> (live_q == $past(value)));
   p_pwm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && !reload) |=> $stable(live_q));
   p_force_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (force_m && !eq && !flag) |=> !flag);
endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank #(
   parameter int CNT_W = 10,
   parameter int BUS_W = 8,
   parameter int N_CH  = 4,
   localparam int CH_W = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             at_top_i,
   input  logic             at_bottom_i,
   input  logic             pwm_mode_i,
   input  logic             upd_top_i,
   input  logic             bus_we_i,
   input  logic             bus_hi_i,
   input  logic [CH_W-1:0]  bus_ch_i,
   input  logic [BUS_W-1:0] bus_data_i,
   input  logic             flag_clr_we_i,
   input  logic [N_CH-1:0]  flag_clr_i,
   input  logic [N_CH-1:0]  irq_en_i,
   input  logic [N_CH-1:0]  irq_ack_i,
   input  logic [N_CH-1:0]  force_i,
   output logic [N_CH-1:0]  match_o,
   output logic [N_CH-1:0]  flag_o,
   output logic [N_CH-1:0]  irq_o
);
   import tcmp_pkg::*;

   if (CNT_W <= BUS_W || CNT_W >= 2 * BUS_W) begin : g_bad_width
      $error("tcmp_bank: CNT_W must exceed BUS_W and stay below 2*BUS_W");
   end
   if (N_CH < 2) begin : g_bad_ch
      $error("tcmp_bank: N_CH must be at least 2");
   end

   logic [N_CH-1:0]  commit;
   logic [CNT_W-1:0] value;
   logic             reload;
   reload_sel_e      sel;

   assign sel    = reload_sel_e'(upd_top_i);
   assign reload = reload_now(pwm_mode_i, sel, at_top_i, at_bottom_i);

   tcmp_hold_latch #(.CNT_W(CNT_W), .BUS_W(BUS_W), .N_CH(N_CH)) u_hold (
      .clk(clk), .rst_n(rst_n), .we(bus_we_i), .hi(bus_hi_i), .ch(bus_ch_i),
      .data(bus_data_i), .commit(commit), .value(value));

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      tcmp_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .cnt(cnt_i), .pwm(pwm_mode_i),
         .reload(reload), .commit(commit[g]), .value(value),
         .force_m(force_i[g]), .ack(irq_ack_i[g]),
         .clr(flag_clr_we_i && flag_clr_i[g]), .ien(irq_en_i[g]),
         .match(match_o[g]), .flag(flag_o[g]), .irq(irq_o[g]));
   end

   p_one_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(commit) <= 1);
   p_hi_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && bus_hi_i) |-> (commit == '0));
endmodule

// File: tb/tb_tcmp_bank.sv
module tb_tcmp_bank;
   logic       clk = 0, rst_n = 0;
   logic [9:0] cnt_i = 0;
   logic       at_top_i = 0, at_bottom_i = 0, pwm_mode_i = 0, upd_top_i = 0;
   logic       bus_we_i = 0, bus_hi_i = 0;
   logic [1:0] bus_ch_i = 0;
   logic [7:0] bus_data_i = 0;
   logic       flag_clr_we_i = 0;
   logic [3:0] flag_clr_i = 0, irq_en_i = 0, irq_ack_i = 0, force_i = 0;
   logic [3:0] match_o, flag_o, irq_o;

   tcmp_bank dut (.*);

   always #4 clk = ~clk;

   int    checks = 0, fails = 0, cycles = 0;
   string scen = "R1";
   int    live[4], shadow[4], hold;
   bit    flg[4];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin live[i] = 0; shadow[i] = 0; flg[i] = 0; end
         hold = 0;
      end else begin
         automatic bit rl = pwm_mode_i && (upd_top_i ? at_top_i : at_bottom_i);
         automatic int val = hold * 256 + bus_data_i;
         for (int i = 0; i < 4; i++) begin
            if (cnt_i == live[i]) flg[i] = 1;
            else if (irq_ack_i[i] || (flag_clr_we_i && flag_clr_i[i])) flg[i] = 0;
         end
         if (pwm_mode_i) begin
            if (rl) for (int i = 0; i < 4; i++) live[i] = shadow[i];
            if (bus_we_i && !bus_hi_i) shadow[bus_ch_i] = val;
         end else if (bus_we_i && !bus_hi_i) begin
            live[bus_ch_i] = val;
            shadow[bus_ch_i] = val;
         end
         if (bus_we_i && bus_hi_i) hold = bus_data_i[1:0];
      end
   end

   task automatic cmp(string what, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s) at %0t: actual %b expected %b", what, scen, $time, act, exp);
      end
   endtask

   task automatic tick();
      logic [3:0] em, ef, ei;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         em[i] = (int'(cnt_i) == live[i]) || force_i[i];
         ef[i] = flg[i];
         ei[i] = flg[i] && irq_en_i[i];
      end
      cmp("R2 match", match_o, em);
      cmp("R3 flag", flag_o, ef);
      cmp("R4 irq", irq_o, ei);
      bus_we_i = 0; flag_clr_we_i = 0; irq_ack_i = 0; force_i = 0;
      at_top_i = 0; at_bottom_i = 0;
   endtask

   task automatic wr(int ch, int val);
      bus_we_i = 1; bus_hi_i = 1; bus_ch_i = 2'(ch); bus_data_i = 8'(val >> 8);
      tick();
      bus_we_i = 1; bus_hi_i = 0; bus_ch_i = 2'(ch); bus_data_i = 8'(val);
      tick();
   endtask

   task automatic sweep(int n);
      for (int k = 0; k < n; k++) begin
         cnt_i = cnt_i + 10'd1;
         at_top_i = (cnt_i == 10'h3FF);
         at_bottom_i = (cnt_i == 10'h000);
         tick();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      scen = "R1";
      cmp("R1 flags in reset", flag_o, 4'b0);
      cmp("R1 irq in reset", irq_o, 4'b0);
      cnt_i = 10'd7;
      rst_n = 1;
      tick();
      cmp("R1 match after reset", match_o, 4'b0);

      scen = "R7/R8 normal writes";
      wr(0, 'h155); wr(1, 'h2AA); wr(2, 'h3FF); wr(3, 'h010);
      scen = "R7 high byte alone";
      bus_we_i = 1; bus_hi_i = 1; bus_ch_i = 0; bus_data_i = 8'h03;
      tick();
      sweep(40);

      scen = "R2/R3/R4 sweep";
      irq_en_i = 4'b0101;
      sweep(1100);

      scen = "R5 ack";
      irq_ack_i = 4'b1111; tick(); tick();
      sweep(1030);
      scen = "R6 clear";
      flag_clr_we_i = 1; flag_clr_i = 4'b0011; tick();
      flag_clr_we_i = 1; flag_clr_i = 4'b0000; tick();
      flag_clr_we_i = 1; flag_clr_i = 4'b1100; tick();

      scen = "R9 pwm top reload";
      pwm_mode_i = 1; upd_top_i = 1;
      wr(0, 'h020); wr(1, 'h300); wr(2, 'h0F0); wr(3, 'h1C4);
      sweep(1100);
      scen = "R9 pwm bottom reload";
      upd_top_i = 0;
      wr(0, 'h3F0); wr(2, 'h001);
      sweep(1100);

      scen = "R10 force";
      flag_clr_we_i = 1; flag_clr_i = 4'b1111; tick();
      cnt_i = 10'd500;
      force_i = 4'b1111; tick();
      force_i = 4'b0110; tick();
      tick();

      scen = "R2-mixed random";
      pwm_mode_i = 0;
      for (int k = 0; k < 4000; k++) begin
         cnt_i = 10'($urandom_range(0, 1023));
         if ($urandom_range(0, 15) == 0) cnt_i = 10'(live[$urandom_range(0, 3)]);
         pwm_mode_i = ($urandom_range(0, 99) == 0) ? ~pwm_mode_i : pwm_mode_i;
         upd_top_i = 1'($urandom);
         at_top_i = ($urandom_range(0, 7) == 0);
         at_bottom_i = ($urandom_range(0, 7) == 0);
         bus_we_i = ($urandom_range(0, 3) == 0);
         bus_hi_i = 1'($urandom);
         bus_ch_i = 2'($urandom);
         bus_data_i = 8'($urandom);
         flag_clr_we_i = ($urandom_range(0, 7) == 0);
         flag_clr_i = 4'($urandom);
         irq_en_i = 4'($urandom);
         irq_ack_i = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
         force_i = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0;
         tick();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog (%s): actual hung expected done", scen);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule